// File: doc/BRIEF.md
# Multi-Mode Static Memory Sequencer

This block turns single read and write requests from an on-chip bus master into timed cycles on one external static-memory chip select. A 3-bit protocol selector chooses how reads are run: plain asynchronous, asynchronous page mode with 4, 8 or 16 words per page, synchronous burst with or without a burst-advance strobe, or synchronous pipelined burst. Writes always run as asynchronous cycles. The device side is 16 bits wide. A 32-bit host access therefore takes two device words, and a burst takes eight.

All memory timing is counted in periods of a reference clock. The reference clock is the system clock divided by a programmable even ratio. The protocol, divider and both wait counts are sampled when a request is accepted, so changing them during an access has no effect on it. The external memory clock pin toggles only during accesses in the synchronous protocols. Requests that break the alignment rules get an error acknowledge and never touch the memory pins.

Top module: `smc_seq`

## Requirements
- R1: The reference period is 2*(cfg_div+1) system cycles, with cfg_div in 0..3. Every memory-side output changes only at a period boundary. Protocol, divider and wait counts are captured at acceptance, and later changes do not affect the access in progress.
- R2: mem_clk is high in the first half of each reference period during accesses whose protocol is 4, 5 or 7, including writes. It is low at all other times, which covers idle and protocols 0, 1, 2, 3 and 6.
- R3: With protocol 0 (and 6), every read word lasts cfg_wfirst+1 periods. mem_addr is the 16-bit word address (byte address divided by 2) plus the word index.
- R4: With protocols 1, 2 and 3, the page size is 4, 8 and 16 words. The first word, and any later word whose address is a multiple of the page size, lasts cfg_wfirst+1 periods. Other words last cfg_wbeat+1 periods.
- R5: With protocols 4 and 5, the first read word lasts cfg_wfirst+1 periods and each later word lasts cfg_wbeat+1. mem_next is high during every read word after the first, and only with protocol 4.
- R6: With protocol 7, the first read word lasts cfg_wfirst+1 periods and each later word lasts one period.
- R7: A write drives each word for cfg_wfirst+2 periods. mem_we_n is low in all of those periods except the last. mem_dq_oe is high and mem_oe_n is high. The first word is host_wdata[15:0] and the second is host_wdata[31:16].
- R8: Read data is captured at the end of each word. host_rvalid pulses the cycle after a word completes a host word. A 32-bit word is {second, first}, a 16-bit read is zero-extended, and a burst gives four pulses.
- R9: host_ack pulses for one cycle, with host_err low, in the cycle after the final period of the last word. mem_cs_n is high from that cycle on.
- R10: A request is rejected in three cases: a 32-bit access with address bits [1:0] not zero, a 16-bit access with bit 0 set, or a burst that is a write or has address bits [3:0] not zero. A rejected request gets host_ack and host_err high in the next cycle, and mem_cs_n stays high.
- R11: mem_cs_n is low for the whole access. mem_adv_n is low only during its first reference period. mem_oe_n is low for the whole of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 3 | Read protocol selector |
| cfg_div | input | 2 | Divider code, ratio 2*(code+1) |
| cfg_wfirst | input | WW | Wait periods for the first or random word |
| cfg_wbeat | input | WW | Wait periods for following page or burst words |
| host_req | input | 1 | Request strobe, taken when idle |
| host_we | input | 1 | 1 = write |
| host_sz32 | input | 1 | 1 = 32-bit, 0 = 16-bit |
| host_burst | input | 1 | Four-word incrementing burst |
| host_addr | input | AW | Byte address |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | Completion pulse |
| host_err | output | 1 | Rejection flag, valid with host_ack |
| host_rvalid | output | 1 | Read word valid pulse |
| host_rdata | output | 32 | Read word |
| mem_cs_n | output | 1 | Chip select |
| mem_oe_n | output | 1 | Output enable |
| mem_we_n | output | 1 | Write enable |
| mem_adv_n | output | 1 | Address valid strobe |
| mem_next | output | 1 | Burst advance |
| mem_clk | output | 1 | External memory clock |
| mem_addr | output | AW-1 | Word address |
| mem_dq_o | output | 16 | Write data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Read data from memory |

## Verification
The hardest case to reach is the page-boundary restart. A burst only crosses a page in 4-word page mode, and the long first-word wait then reappears at the fifth word. The stimulus reaches it with a burst under protocol 1 using very different first and page waits. It also rewrites the divider, protocol and wait inputs in the cycle after acceptance, which exposes any setting that is not held for the whole access. A behavioural model builds the per-word period schedule for each access and compares every memory and host output on every cycle.

// File: rtl/smc_seq.sv
module smc_seq #(
  parameter int AW = 24,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_mode,
  input  logic [1:0]    cfg_div,
  input  logic [WW-1:0] cfg_wfirst,
  input  logic [WW-1:0] cfg_wbeat,
  input  logic          host_req,
  input  logic          host_we,
  input  logic          host_sz32,
  input  logic          host_burst,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic          host_ack,
  output logic          host_err,
  output logic          host_rvalid,
  output logic [31:0]   host_rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_adv_n,
  output logic          mem_next,
  output logic          mem_clk,
  output logic [AW-2:0] mem_addr,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);
  localparam int CW = WW + 1;

  logic          busy, wr, sz, firstp;
  logic [2:0]    m, beat, nb;
  logic [3:0]    dv, ph, pmask;
  logic [CW-1:0] cnt, lat_nx;
  logic [AW-2:0] base, nxt;
  logic [WW-1:0] wf, wb;
  logic [31:0]   wdat;
  logic [15:0]   lo;

  wire bad = host_burst ? (host_we || host_addr[3:0] != 4'd0)
                        : (host_sz32 ? host_addr[1:0] != 2'd0 : host_addr[0]);
  wire accept  = host_req && !busy;
  wire sync    = (m == 3'd4) || (m == 3'd5) || (m == 3'd7);
  wire per_end = (ph == dv - 4'd1);

  assign mem_addr  = base + {{(AW-4){1'b0}}, beat};
  assign nxt       = mem_addr + 1'b1;
  assign mem_cs_n  = ~busy;
  assign mem_oe_n  = ~(busy & ~wr);
  assign mem_we_n  = ~(busy & wr & (cnt != '0));
  assign mem_adv_n = ~(busy & firstp);
  assign mem_next  = busy & ~wr & (m == 3'd4) & (beat != 3'd0);
  assign mem_clk   = busy & sync & (ph < (dv >> 1));
  assign mem_dq_oe = busy & wr;
  assign mem_dq_o  = beat[0] ? wdat[31:16] : wdat[15:0];

  always_comb begin
    case (m)
      3'd1:    pmask = 4'd3;
      3'd2:    pmask = 4'd7;
      3'd3:    pmask = 4'd15;
      default: pmask = 4'd0;
    endcase
    lat_nx = {1'b0, wf};
    if (wr)                              lat_nx = {1'b0, wf} + 1'b1;
    else if (m == 3'd7)                  lat_nx = '0;
    else if (m == 3'd4 || m == 3'd5)     lat_nx = {1'b0, wb};
    else if (pmask != 4'd0 && (nxt[3:0] & pmask) != 4'd0) lat_nx = {1'b0, wb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; wr <= 1'b0; sz <= 1'b0; firstp <= 1'b0;
      m <= '0; beat <= '0; nb <= '0; dv <= 4'd2; ph <= '0; cnt <= '0;
      base <= '0; wf <= '0; wb <= '0; wdat <= '0; lo <= '0;
      host_ack <= 1'b0; host_err <= 1'b0; host_rvalid <= 1'b0; host_rdata <= '0;
    end else begin
      host_ack <= 1'b0;
      host_err <= 1'b0;
      host_rvalid <= 1'b0;
      if (accept) begin
        if (bad) begin
          host_ack <= 1'b1;
          host_err <= 1'b1;
        end else begin
          busy   <= 1'b1;
          wr     <= host_we;
          sz     <= host_sz32 | host_burst;
          m      <= cfg_mode;
          dv     <= ({2'b0, cfg_div} + 4'd1) << 1;
          wf     <= cfg_wfirst;
          wb     <= cfg_wbeat;
          base   <= host_addr[AW-1:1];
          wdat   <= host_wdata;
          ph     <= '0;
          beat   <= '0;
          firstp <= 1'b1;
          nb     <= host_burst ? 3'd7 : (host_sz32 ? 3'd1 : 3'd0);
          cnt    <= host_we ? {1'b0, cfg_wfirst} + 1'b1 : {1'b0, cfg_wfirst};
        end
      end else if (busy) begin
        ph <= per_end ? 4'd0 : ph + 4'd1;
        if (per_end) begin
          firstp <= 1'b0;
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            if (!wr) begin
              lo <= mem_dq_i;
              if (beat[0] || !sz) begin
                host_rvalid <= 1'b1;
                host_rdata  <= sz ? {mem_dq_i, lo} : {16'h0, mem_dq_i};
              end
            end
            if (beat == nb) begin
              busy     <= 1'b0;
              host_ack <= 1'b1;
            end else begin
              beat <= beat + 3'd1;
              cnt  <= lat_nx;
            end
          end
        end
      end
    end
  end

  a_r1_period_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph != 4'd0) |-> $stable({mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_next, mem_addr, mem_dq_oe}));
  a_r7_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r5_next_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_next |-> (!mem_oe_n && mem_adv_n));
  a_r9_ack_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && !host_err) |-> ($past(!mem_cs_n) && mem_cs_n));
  a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad) |=> (host_ack && host_err && mem_cs_n));
  a_r11_adv_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> !mem_adv_n);
  a_r2_clk_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clk |-> !mem_cs_n);
endmodule

// File: tb/smc_seq_tb.sv
`timescale 1ns/1ps
module smc_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [1:0] cfg_div = '0;
  logic [3:0] cfg_wfirst = '0, cfg_wbeat = '0;
  logic host_req = 0, host_we = 0, host_sz32 = 0, host_burst = 0;
  logic [23:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_ack, host_err, host_rvalid;
  logic [31:0] host_rdata;
  logic mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_next, mem_clk, mem_dq_oe;
  logic [22:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;
  int checks = 0, errors = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] wordv(input logic [22:0] wa);
    return {wa[7:0] ^ 8'hA5, wa[7:0]};
  endfunction
  assign mem_dq_i = wordv(mem_addr);

  smc_seq u_dut (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(tag, "cs_n idle", mem_cs_n, 1);
      chk(tag, "oe_n idle", mem_oe_n, 1);
      chk(tag, "we_n idle", mem_we_n, 1);
      chk(tag, "adv_n idle", mem_adv_n, 1);
      chk(tag, "clk idle", mem_clk, 0);
      chk(tag, "next idle", mem_next, 0);
      chk(tag, "dq_oe idle", mem_dq_oe, 0);
      chk(tag, "ack idle", host_ack, 0);
      @(negedge clk);
    end
  endtask

  task automatic run_acc(input int mode, input int dcode, input int wf, input int wb,
                         input bit we, input bit sz, input bit bst,
                         input logic [23:0] a, input logic [31:0] wd, input string tag);
    int dv, nb, psz;
    int lat[8];
    logic [22:0] base, wa;
    bit bad, sync, rvp, rvn;
    logic [31:0] rexp, rnx;
    logic [15:0] lo, w;
    dv = 2 * (dcode + 1);
    nb = bst ? 8 : (sz ? 2 : 1);
    base = a[23:1];
    bad = bst ? (we || a[3:0] != 0) : (sz ? a[1:0] != 0 : a[0]);
    sync = (mode == 4 || mode == 5 || mode == 7);
    for (int k = 0; k < nb; k++) begin
      wa = base + 23'(k);
      if (we) lat[k] = wf + 2;
      else if (k == 0) lat[k] = wf + 1;
      else if (mode >= 1 && mode <= 3) begin
        psz = 4 << (mode - 1);
        lat[k] = (int'(wa) % psz == 0) ? wf + 1 : wb + 1;
      end
      else if (mode == 4 || mode == 5) lat[k] = wb + 1;
      else if (mode == 7) lat[k] = 1;
      else lat[k] = wf + 1;
    end
    cfg_mode = 3'(mode); cfg_div = 2'(dcode); cfg_wfirst = 4'(wf); cfg_wbeat = 4'(wb);
    host_req = 1; host_we = we; host_sz32 = sz; host_burst = bst; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_req = 0;
    // R1: settings changed after acceptance must not matter
    cfg_div = 2'(3 - dcode); cfg_mode = (mode == 7) ? 3'd0 : 3'd7;
    cfg_wfirst = 4'(15 - wf); cfg_wbeat = 4'(15 - wb); host_wdata = ~wd;
    if (bad) begin
      chk(tag, "R10 ack", host_ack, 1);
      chk(tag, "R10 err", host_err, 1);
      chk(tag, "R10 cs_n", mem_cs_n, 1);
      @(negedge clk);
      idle_chk(2, tag);
      return;
    end
    rvp = 0; rexp = '0; lo = '0;
    for (int k = 0; k < nb; k++) begin
      for (int q = 0; q < lat[k]; q++) begin
        for (int p = 0; p < dv; p++) begin
          chk(tag, "R11 cs_n", mem_cs_n, 0);
          chk(tag, "R11 oe_n", mem_oe_n, we);
          chk(tag, "R7 we_n", mem_we_n, we ? (q == lat[k] - 1) : 1);
          chk(tag, "R11 adv_n", mem_adv_n, !(k == 0 && q == 0));
          chk(tag, "R5 next", mem_next, (mode == 4 && !we && k > 0));
          chk(tag, "R2 clk", mem_clk, sync && (p < dv / 2));
          chk(tag, "R3 addr", 32'(mem_addr), 32'(base + 23'(k)));
          chk(tag, "R7 dq_oe", mem_dq_oe, we);
          if (we) chk(tag, "R7 dq_o", mem_dq_o, k[0] ? wd[31:16] : wd[15:0]);
          chk(tag, "R9 ack", host_ack, 0);
          chk(tag, "R8 rvalid", host_rvalid, rvp);
          if (rvp) chk(tag, "R8 rdata", host_rdata, rexp);
          rvn = 0; rnx = rexp;
          if (!we && q == lat[k] - 1 && p == dv - 1) begin
            w = wordv(base + 23'(k));
            if (!sz) begin rvn = 1; rnx = {16'h0, w}; end
            else if (k % 2 == 1) begin rvn = 1; rnx = {w, lo}; end
            lo = w;
          end
          rvp = rvn; rexp = rnx;
          @(negedge clk);
        end
      end
    end
    chk(tag, "R9 ack end", host_ack, 1);
    chk(tag, "R9 err end", host_err, 0);
    chk(tag, "R9 cs_n end", mem_cs_n, 1);
    chk(tag, "R8 rvalid end", host_rvalid, rvp);
    if (rvp) chk(tag, "R8 rdata end", host_rdata, rexp);
    @(negedge clk);
    idle_chk(2, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", "reset ack", host_ack, 0);
    chk("R8", "reset rvalid", host_rvalid, 0);
    idle_chk(2, "R11 reset");
    run_acc(0, 0, 2, 0, 0, 1, 0, 24'h000100, 0, "R3 m0 rd32");
    run_acc(6, 1, 1, 3, 0, 0, 0, 24'h000012, 0, "R3 m6 rd16");
    run_acc(1, 0, 3, 0, 0, 1, 1, 24'h000040, 0, "R4 m1 burst");
    run_acc(2, 1, 2, 1, 0, 1, 1, 24'h000080, 0, "R4 m2 burst");
    run_acc(3, 0, 2, 0, 0, 1, 1, 24'h0000F0, 0, "R4 m3 burst");
    run_acc(2, 0, 1, 0, 0, 1, 0, 24'h000204, 0, "R4 m2 rd32");
    run_acc(4, 2, 2, 1, 0, 1, 1, 24'h000300, 0, "R5 m4 burst");
    run_acc(5, 3, 1, 2, 0, 1, 1, 24'h000410, 0, "R5 m5 burst");
    run_acc(7, 0, 1, 5, 0, 1, 1, 24'h000520, 0, "R6 m7 burst");
    run_acc(7, 1, 0, 0, 0, 0, 0, 24'h000602, 0, "R6 m7 rd16");
    run_acc(0, 0, 1, 0, 1, 1, 0, 24'h000700, 32'hCAFE_1234, "R7 m0 wr32");
    run_acc(4, 1, 0, 0, 1, 0, 0, 24'h000706, 32'h0000_BEEF, "R7 m4 wr16");
    run_acc(0, 0, 1, 1, 0, 1, 0, 24'h000002, 0, "R10 mis32");
    run_acc(0, 0, 1, 1, 0, 0, 0, 24'h000001, 0, "R10 mis16");
    run_acc(4, 0, 1, 1, 0, 1, 1, 24'h000008, 0, "R10 burst start");
    run_acc(4, 0, 1, 1, 1, 1, 1, 24'h000010, 32'h1, "R10 burst write");
    run_acc(0, 3, 0, 0, 0, 0, 0, 24'h000800, 0, "R1 div8 rd16");
    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule